// File: doc/BRIEF.md
# Autoreload Timebase Timer with Wake Logic

This block is an 8-bit periodic timebase for a small microcontroller subsystem. An internal divide-by-32 prescaler turns the system clock into a slow count enable. Each count enable advances an 8-bit up-counter. When the counter is at 0xFF and is advanced again, it does not wrap to zero. It reloads from a software-written autoreload register and raises an overflow flag. Software chooses the period through the reload value: with reload R, one overflow occurs every (256 - R) * 32 active clock cycles.

Software reaches the block through a byte-wide register bus with a combinational read path. There are three registers: a control/status register, the autoreload register and a read-only view of the counter. Reading the control/status register acknowledges the overflow flag. An interrupt request goes out while the flag and the enable are both set.

The block also takes a power-mode input. The timer keeps counting in every mode except the deepest sleep mode, where both the counter and the prescaler freeze. A pending, enabled overflow may wake the core only from the shallow wait mode.

Top module: `tbt_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it, every register reads 0x00 and `irq` and `wake` are low.
- R2: Register addresses: 0 is the control/status register, 1 is the autoreload register, 2 is the counter and 3 reads 0x00. In the control/status register, bit 1 is the interrupt enable (read/write), bit 0 is the overflow flag, and bits 7:2 always read 0.
- R3: The counter advances by one on every 32nd cycle in which counting is allowed. An advance from 0xFF loads the autoreload value and sets the overflow flag, so overflows recur every (256 - R) * 32 counting cycles.
- R4: The counter register is read-only. A write to address 2 leaves the counter unchanged.
- R5: The autoreload register reads back the last byte written to it.
- R6: A new autoreload value has no effect on the count already in progress. It is first used at the next overflow.
- R7: Power-mode codes are 0 = run, 1 = slow, 2 = wait, 3 = active-halt and 4 = halt; codes 5 to 7 behave as run. Counting continues in all modes except halt. In halt, the counter and the prescaler both hold their values.
- R8: A bus read of address 0 clears the overflow flag at the next clock edge. If an overflow happens in the same cycle as that read, the flag stays set.
- R9: A bus write to the control/status register never changes the overflow flag, whatever value is written to bit 0.
- R10: `irq` is high exactly when the overflow flag and the interrupt enable are both set.
- R11: `wake` is high only while the mode is wait and the flag and the enable are both set. It is low in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_mode | input | 3 | Power-mode code (see R7) |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the addressed register |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request to the power controller |

## Verification
The assertions check on every cycle the rules that hold from one clock edge to the next: the counter steps or reloads on a tick, holds without one, freezes in halt, the flag rises only on an overflow, a read clears it unless an overflow coincides, and `wake` is never high outside wait mode. The bench scenarios cover what only shows up over many cycles: the exact overflow period for a given reload, the deferred effect of a reload write, the stretch of a halt that is not a whole prescaler period, and the register values seen across the bus after writes to the flag bit and to the read-only counter.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int PRESC_W = 5;

    typedef enum logic [2:0] {
        PM_RUN   = 3'd0,
        PM_SLOW  = 3'd1,
        PM_WAIT  = 3'd2,
        PM_AHALT = 3'd3,
        PM_HALT  = 3'd4
    } pwr_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CSR    = 2'd0,
        RA_RELOAD = 2'd1,
        RA_COUNT  = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic ie;
        logic flag;
    } csr_t;

    // Unknown codes fall back to run.
    function automatic pwr_mode_e decode_mode(input logic [2:0] raw);
        case (raw)
            3'd1:    return PM_SLOW;
            3'd2:    return PM_WAIT;
            3'd3:    return PM_AHALT;
            3'd4:    return PM_HALT;
            default: return PM_RUN;
        endcase
    endfunction

    function automatic logic mode_counts(input pwr_mode_e m);
        return m != PM_HALT;
    endfunction

    function automatic logic mode_may_wake(input pwr_mode_e m);
        return m == PM_WAIT;
    endfunction

endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
    parameter int DIV_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam logic [DIV_W-1:0] LAST = '1;

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = run && (div_q == LAST);

endmodule

// File: rtl/tbt_counter.sv
module tbt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    assign ovf = tick && (cnt_q == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ovf) begin
            cnt_q <= reload;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/tbt_regs.sv
module tbt_regs
    import tbt_pkg::*;
#(
    parameter int W = 8,
    parameter int A = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  logic         wr,
    input  logic [A-1:0] addr,
    input  logic [W-1:0] wdata,
    input  logic         ovf,
    input  logic [W-1:0] count,
    output logic [W-1:0] reload,
    output csr_t         csr,
    output logic         csr_rd,
    output logic [W-1:0] rdata
);
    csr_t         csr_q, csr_d;
    logic [W-1:0] reload_q;
    logic         csr_wr, rel_wr;

    assign csr_rd = sel && !wr && (addr == RA_CSR);
    assign csr_wr = sel &&  wr && (addr == RA_CSR);
    assign rel_wr = sel &&  wr && (addr == RA_RELOAD);

    always_comb begin
        csr_d = csr_q;
        if (csr_wr) begin
            csr_d.ie = wdata[1];
        end
        // A hardware set outranks the acknowledge by read.
        if (ovf) begin
            csr_d.flag = 1'b1;
        end else if (csr_rd) begin
            csr_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_q    <= '0;
            reload_q <= '0;
        end else begin
            csr_q <= csr_d;
            if (rel_wr) begin
                reload_q <= wdata;
            end
        end
    end

    always_comb begin
        case (addr)
            RA_CSR:    rdata = W'(csr_q);
            RA_RELOAD: rdata = reload_q;
            RA_COUNT:  rdata = count;
            default:   rdata = '0;
        endcase
    end

    assign reload = reload_q;
    assign csr    = csr_q;

endmodule

// File: rtl/tbt_timer.sv
module tbt_timer
    import tbt_pkg::*;
#(
    parameter int DATA_W  = tbt_pkg::DATA_W,
    parameter int ADDR_W  = tbt_pkg::ADDR_W,
    parameter int PRESC_W = tbt_pkg::PRESC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        pwr_mode,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wake
);
    pwr_mode_e         mode;
    logic              run;
    logic              tick;
    logic              ovf;
    logic              csr_rd;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] reload_q;
    csr_t              csr;
    logic              flag_q, ie_q;

    assign mode   = decode_mode(pwr_mode);
    assign run    = mode_counts(mode);
    assign flag_q = csr.flag;
    assign ie_q   = csr.ie;

    tbt_prescaler #(.DIV_W(PRESC_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    tbt_counter #(.W(DATA_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .reload (reload_q),
        .count  (cnt_q),
        .ovf    (ovf)
    );

    tbt_regs #(.W(DATA_W), .A(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .ovf    (ovf),
        .count  (cnt_q),
        .reload (reload_q),
        .csr    (csr),
        .csr_rd (csr_rd),
        .rdata  (bus_rdata)
    );

    assign irq  = flag_q && ie_q;
    assign wake = irq && mode_may_wake(mode);

endmodule

// File: rtl/tbt_timer_chk.sv
module tbt_timer_chk
    import tbt_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   pwr_mode,
    input logic         tick,
    input logic         ovf,
    input logic         csr_rd,
    input logic [W-1:0] cnt,
    input logic [W-1:0] reload,
    input logic         flag,
    input logic         irq,
    input logic         wake
);
    localparam logic [W-1:0] TOP = '1;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt == '0) && !flag && !irq && !wake);

    // R3
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt != TOP) |=> cnt == W'($past(cnt) + 1'b1));

    // R3, R6
    a_r3_ovf_reload: assert property (@(posedge clk) disable iff (rst)
        ovf |=> cnt == $past(reload));

    // R4
    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!rst && !tick) |=> $stable(cnt));

    // R7
    a_r7_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        (!rst && pwr_mode == 3'(PM_HALT)) |=> $stable(cnt));

    // R8
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        ovf |=> flag);

    // R8
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (csr_rd && !ovf) |=> !flag);

    // R9
    a_r9_rise_only_on_ovf: assert property (@(posedge clk) disable iff (rst)
        !ovf |=> !$rose(flag));

    // R11
    a_r11_wake_only_wait: assert property (@(posedge clk) disable iff (rst)
        wake |-> (pwr_mode == 3'(PM_WAIT)) && irq);

endmodule

bind tbt_timer tbt_timer_chk #(.W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_mode (pwr_mode),
    .tick     (tick),
    .ovf      (ovf),
    .csr_rd   (csr_rd),
    .cnt      (cnt_q),
    .reload   (reload_q),
    .flag     (flag_q),
    .irq      (irq),
    .wake     (wake)
);

// File: tb/tbt_timer_tb.sv
module tbt_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] pwr_mode = 3'd0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, wake;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tbt_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .pwr_mode  (pwr_mode),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .wake      (wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // Poll until irq shows; returns on the negedge right after the overflow edge.
    task automatic wait_irq(input string tag);
        int k = 0;
        while (!irq && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk(tag, irq, 1'b1);
    endtask

    // Starts with the flag pending, acknowledges it, then counts cycles to the next overflow.
    task automatic time_period(input string tag, input logic [2:0] hmode, input int hstart,
                               input int hlen, input int rel_at, input logic [7:0] rel_val,
                               input int rd_at, input int exp_m);
        logic [7:0] d;
        int m = 0;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
        #1 chk({tag, " R8 flag visible in status"}, bus_rdata, 8'h03);
        while (1) begin
            @(negedge clk);
            m++;
            bus_sel = 1'b0; bus_wr = 1'b0;
            if (irq || m >= 4000) break;
            if (m == hstart) pwr_mode = hmode;
            if (m == hstart + hlen) pwr_mode = 3'd0;
            if (m == rel_at) begin
                bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = rel_val;
            end
            if (m == rd_at) begin
                bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
                #1 d = bus_rdata;
                chk({tag, " R8 flag clear before coincident read"}, d[0], 1'b0);
            end
        end
        pwr_mode = 3'd0;
        chk(tag, m, exp_m);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 irq in reset", irq, 1'b0);
        chk("R1 wake in reset", wake, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        bus_read(2'd0, d); chk("R1 status reset", d, 8'h00);
        bus_read(2'd1, d); chk("R1 reload reset", d, 8'h00);
        bus_read(2'd2, d); chk("R1 counter reset", d, 8'h00);
    endtask

    task automatic t_config;
        logic [7:0] d;
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, d);  chk("R2 reserved bits zero, enable set", d, 8'h02);
        bus_write(2'd1, 8'hF0);
        bus_read(2'd1, d);  chk("R5 reload readback", d, 8'hF0);
        bus_read(2'd3, d);  chk("R2 unused address reads zero", d, 8'h00);
        wait_irq("R3 first overflow from reset");
    endtask

    task automatic t_periods;
        time_period("R3 period for reload F0", 3'd0, -10, 0, -1, 8'h00, -1, 512);
        time_period("R6 new reload deferred", 3'd0, -10, 0, 5, 8'hE0, -1, 512);
        time_period("R6 new reload used", 3'd0, -10, 0, 5, 8'hF0, -1, 1024);
        time_period("R3 period restored", 3'd0, -10, 0, -1, 8'h00, -1, 512);
    endtask

    task automatic t_modes;
        time_period("R7 halt stretches by 40", 3'd4, 10, 40, -1, 8'h00, -1, 552);
        time_period("R7 active-halt counts", 3'd3, 10, 100, -1, 8'h00, -1, 512);
        time_period("R7 wait counts", 3'd2, 10, 100, -1, 8'h00, -1, 512);
        time_period("R7 slow counts", 3'd1, 10, 100, -1, 8'h00, -1, 512);
        time_period("R7 code 6 counts", 3'd6, 10, 100, -1, 8'h00, -1, 512);
    endtask

    task automatic t_set_wins;
        time_period("R8 set wins over read", 3'd0, -10, 0, -1, 8'h00, 511, 512);
    endtask

    task automatic t_wake;
        pwr_mode = 3'd2; #1 chk("R11 wake in wait", wake, 1'b1);
        pwr_mode = 3'd3; #1 chk("R11 no wake in active-halt", wake, 1'b0);
        pwr_mode = 3'd4; #1 chk("R11 no wake in halt", wake, 1'b0);
        pwr_mode = 3'd1; #1 chk("R11 no wake in slow", wake, 1'b0);
        pwr_mode = 3'd0; #1 chk("R11 no wake in run", wake, 1'b0);
    endtask

    task automatic t_flag_bits;
        logic [7:0] d;
        bus_write(2'd0, 8'h02);
        chk("R9 write of 0 to flag ignored", irq, 1'b1);
        bus_write(2'd0, 8'h00);
        chk("R10 irq low with enable off", irq, 1'b0);
        pwr_mode = 3'd2; #1 chk("R11 no wake with enable off", wake, 1'b0);
        pwr_mode = 3'd0;
        bus_read(2'd0, d);  chk("R10 flag still set under disable", d, 8'h01);
        bus_write(2'd0, 8'h03);
        chk("R9 write of 1 to flag ignored", irq, 1'b0);
        bus_read(2'd0, d);  chk("R9 status after write", d, 8'h02);
    endtask

    task automatic t_readonly;
        logic [7:0] a, b;
        pwr_mode = 3'd4;
        bus_read(2'd2, a);
        bus_write(2'd2, 8'h55);
        repeat (40) @(negedge clk);
        bus_read(2'd2, b);
        chk("R4 counter write ignored / R7 halt holds", b, a);
        pwr_mode = 3'd0;
        wait_irq("R3 overflow after halt");
        time_period("R3 period after resync", 3'd0, -10, 0, -1, 8'h00, -1, 512);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog expired: got 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        t_config;
        t_periods;
        t_modes;
        t_set_wins;
        t_wake;
        t_flag_bits;
        t_readonly;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule